// File: doc/BRIEF.md
# Write Strobe Qualifier and Inhibit

This block sits at the pin boundary of a byte-programmable memory. It watches the active-low chip-select, output-enable and write-strobe pins together with a digital supply-good flag. A fast system clock samples all of these inputs. From them the block produces a single-cycle load event carrying one address and one data byte.

A load window opens when chip-select and write strobe are both low while output-enable is high. The window closes on the first of the two strobes to return high. The address is taken when the window opens, which is the falling edge of whichever strobe went low last. The data byte is taken when the window closes, which is the first rising strobe.

Windows shorter than a set number of clock cycles are treated as noise and dropped. Windows are also dropped while the supply is flagged bad, and during a power-up lockout that starts when the supply flag rises. The block also decodes the output-driver enable for reads. The page buffer and the storage array sit downstream and are not part of it.

Top module: `wstrobe_qualifier`

## Requirements
- R1: After reset `ld_valid`, `ld_addr`, `ld_data` and `rd_drive` are all 0.
- R2: A window in which `ce_n`=0, `we_n`=0 and `oe_n`=1 that lasts at least GLITCH_CYC clock cycles and ends by `ce_n` or `we_n` rising produces exactly one one-cycle `ld_valid` pulse, within 3 clock cycles of the rising strobe.
- R3: `ld_addr` equals the `addr` present when the window opened, whether `we_n` or `ce_n` was the later strobe to fall; address changes later in the window are not taken.
- R4: `ld_data` equals the `din` present at the rising strobe that closes the window, whether that strobe is `ce_n` or `we_n`; earlier data in the window is not taken.
- R5: A window shorter than GLITCH_CYC cycles produces no `ld_valid`, and `ld_addr` and `ld_data` keep their previous values.
- R6: A window that ends because `oe_n` falls produces no load. Strobes that go low while `oe_n` is low produce no load.
- R7: For POR_CYC cycles after the synchronized `vcc_ok` rises, no load is produced. After that time, loads are accepted.
- R8: While `vcc_ok` is 0 no load is produced, and a drop of `vcc_ok` restarts the lockout of R7.
- R9: `rd_drive` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1, delayed by SYNC_STAGES cycles. Otherwise it is 0.
- R10: `ld_addr` and `ld_data` change only in a cycle where `ld_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write strobe pin, active low |
| vcc_ok | input | 1 | Supply above sense threshold |
| addr | input | AW | Address bus |
| din | input | DW | Data bus, write direction |
| ld_valid | output | 1 | One-cycle qualified byte-load event |
| ld_addr | output | AW | Address of the last qualified load |
| ld_data | output | DW | Data of the last qualified load |
| rd_drive | output | 1 | Enable for the read output drivers |

## Verification
A wrong internal state shows up at the ports in one of three ways:
- **Window tracking.** If the state that tracks the open window is wrong, `ld_valid` goes missing or doubles. The error is visible two to three cycles after the closing strobe. Glitch-length windows also show it, as an unwanted load.
- **Capture points.** If the address or data is captured at the wrong point, `ld_addr` or `ld_data` carries the late address or the early data. The error appears in the same cycle as the load pulse.
- **Lockout timer.** If the lockout timer is wrong, a load is accepted during the power-up window or refused long after it. This is seen as soon as the first write after a supply rise.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic vcc_ok;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, vcc_ok: 1'b0};

  // Both strobes low with the output driver off: a write window is open.
  function automatic logic write_window(input ctl_t c);
    return !c.ce_n && !c.we_n && c.oe_n;
  endfunction

  // Selected, output enabled and not writing: drive the read bus.
  function automatic logic read_window(input ctl_t c);
    return !c.ce_n && !c.oe_n && c.we_n;
  endfunction

  // Increment that stops at a ceiling.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned top);
    return (v >= top) ? top : v + 1;
  endfunction

endpackage

// File: rtl/wsq_sync.sv
module wsq_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= RST_VAL;
          else        stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[i] <= RST_VAL;
          else        stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/wsq_por_timer.sv
module wsq_por_timer #(
  parameter int unsigned POR_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok_s,
  output logic ready
);

  localparam int unsigned PW = $clog2(POR_CYC + 1);
  localparam logic [PW-1:0] LAST = PW'(POR_CYC);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!vcc_ok_s)  cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign ready = vcc_ok_s && (cnt == LAST);

endmodule

// File: rtl/wsq_strobe_filter.sv
module wsq_strobe_filter
  import wsq_pkg::*;
#(
  parameter int unsigned AW         = 17,
  parameter int unsigned GLITCH_CYC = 3,
  localparam int unsigned CW        = $clog2(GLITCH_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl_s,
  input  logic          ready,
  input  logic [AW-1:0] addr_s,
  output logic          win_open,
  output logic          win_close,
  output logic [CW-1:0] low_cnt,
  output logic [AW-1:0] cand_addr,
  output logic          commit
);

  logic active, active_q, clean;

  assign active    = write_window(ctl_s);
  assign win_open  = active && !active_q;
  assign win_close = !active && active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_cnt <= '0;
    else if (!active) low_cnt <= '0;
    else              low_cnt <= CW'(sat_inc(int'(low_cnt), GLITCH_CYC));
  end

  // Lockout must stay clear for the whole window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 clean <= 1'b0;
    else if (win_open)          clean <= ready;
    else if (active && !ready)  clean <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cand_addr <= '0;
    else if (win_open) cand_addr <= addr_s;
  end

  assign commit = win_close && ctl_s.oe_n && clean && ready &&
                  (int'(low_cnt) >= int'(GLITCH_CYC));

endmodule

// File: rtl/wstrobe_qualifier.sv
module wstrobe_qualifier
  import wsq_pkg::*;
#(
  parameter int unsigned AW          = 17,
  parameter int unsigned DW          = 8,
  parameter int unsigned GLITCH_CYC  = 3,
  parameter int unsigned POR_CYC     = 1000000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          vcc_ok,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          ld_valid,
  output logic [AW-1:0] ld_addr,
  output logic [DW-1:0] ld_data,
  output logic          rd_drive
);

  localparam int unsigned CW = $clog2(GLITCH_CYC + 1);
  localparam int unsigned BW = AW + DW;

  ctl_t          ctl_raw, ctl_s;
  logic [BW-1:0] bus_s;
  logic [AW-1:0] addr_s, cand_addr;
  logic [DW-1:0] din_s;
  logic          wr_ready, win_open, win_close, commit;
  logic [CW-1:0] low_cnt;

  always_comb begin
    ctl_raw.ce_n   = ce_n;
    ctl_raw.we_n   = we_n;
    ctl_raw.oe_n   = oe_n;
    ctl_raw.vcc_ok = vcc_ok;
  end

  wsq_sync #(.W($bits(ctl_t)), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  // Bus delayed by the same depth so it stays aligned with the strobes.
  wsq_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(bus_s)
  );

  assign addr_s = bus_s[BW-1:DW];
  assign din_s  = bus_s[DW-1:0];

  wsq_por_timer #(.POR_CYC(POR_CYC)) u_por (
    .clk(clk), .rst_n(rst_n), .vcc_ok_s(ctl_s.vcc_ok), .ready(wr_ready)
  );

  wsq_strobe_filter #(.AW(AW), .GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .ctl_s(ctl_s), .ready(wr_ready), .addr_s(addr_s),
    .win_open(win_open), .win_close(win_close), .low_cnt(low_cnt),
    .cand_addr(cand_addr), .commit(commit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      ld_addr  <= '0;
      ld_data  <= '0;
    end else begin
      ld_valid <= commit;
      if (commit) begin
        ld_addr <= cand_addr;
        ld_data <= din_s;
      end
    end
  end

  assign rd_drive = read_window(ctl_s);

endmodule

// File: rtl/wstrobe_qualifier_chk.sv
module wstrobe_qualifier_chk #(
  parameter int unsigned AW          = 17,
  parameter int unsigned DW          = 8,
  parameter int unsigned GLITCH_CYC  = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = $clog2(GLITCH_CYC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          vcc_ok,
  input logic          ld_valid,
  input logic [AW-1:0] ld_addr,
  input logic [DW-1:0] ld_data,
  input logic          rd_drive,
  input logic          wr_ready,
  input logic [CW-1:0] low_cnt
);

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid); // R2

  AST_CLOSED_BY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(ce_n || we_n, SYNC_STAGES + 1)); // R2

  AST_WIDTH_MET: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (int'($past(low_cnt)) >= int'(GLITCH_CYC))); // R5

  AST_OE_HIGH_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(oe_n, SYNC_STAGES + 1)); // R6

  AST_LOCKOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(wr_ready)); // R7

  AST_SUPPLY_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(vcc_ok, SYNC_STAGES + 1)); // R8

  AST_READ_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> $past(!ce_n && !oe_n && we_n, SYNC_STAGES)); // R9

  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(ld_addr) || $changed(ld_data)) |-> ld_valid); // R10

endmodule

bind wstrobe_qualifier wstrobe_qualifier_chk #(
  .AW(AW), .DW(DW), .GLITCH_CYC(GLITCH_CYC), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .vcc_ok(vcc_ok), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
  .rd_drive(rd_drive), .wr_ready(wr_ready), .low_cnt(low_cnt)
);

// File: tb/wstrobe_qualifier_tb.sv
`timescale 1ns/1ps
module wstrobe_qualifier_tb;

  localparam int AW  = 17;
  localparam int DW  = 8;
  localparam int GL  = 3;
  localparam int POR = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vcc_ok = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic ld_valid, rd_drive;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;

  int n_chk = 0, n_fail = 0, n_ld = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wstrobe_qualifier #(.AW(AW), .DW(DW), .GLITCH_CYC(GL), .POR_CYC(POR)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .vcc_ok(vcc_ok), .addr(addr), .din(din), .ld_valid(ld_valid),
    .ld_addr(ld_addr), .ld_data(ld_data), .rd_drive(rd_drive)
  );

  always @(negedge clk) if (rst_n && ld_valid) n_ld++;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Opens a window of 'width' cycles. we_last: WE is the later strobe to fall.
  // ce_rise: CE is the first strobe to rise.
  task automatic do_write(input bit we_last, input bit ce_rise,
                          input logic [AW-1:0] a_open, input logic [AW-1:0] a_late,
                          input logic [DW-1:0] d_early, input logic [DW-1:0] d_close,
                          input int width);
    @(negedge clk);
    addr = a_open; din = d_early;
    if (we_last) ce_n = 1'b0; else we_n = 1'b0;
    idle(2);
    if (we_last) we_n = 1'b0; else ce_n = 1'b0;
    @(negedge clk);
    addr = a_late;
    idle(width - 2);
    din = d_close;
    @(negedge clk);
    if (ce_rise) ce_n = 1'b1; else we_n = 1'b1;
    idle(2);
    ce_n = 1'b1; we_n = 1'b1;
    addr = '1; din = 8'h5A;
    idle(6);
  endtask

  task automatic t_reset();
    check("R1 ld_valid", ld_valid, 0);
    check("R1 ld_addr", ld_addr, 0);
    check("R1 ld_data", ld_data, 0);
    check("R1 rd_drive", rd_drive, 0);
  endtask

  task automatic t_por_early();
    int n0 = n_ld;
    do_write(1, 1, 17'h00100, 17'h00200, 8'h11, 8'h22, 6);
    check("R7 lockout after power up", n_ld, n0);
    check("R10 addr held", ld_addr, 0);
    idle(POR + 20);
  endtask

  task automatic t_we_last_ce_rise();
    int n0 = n_ld;
    do_write(1, 1, 17'h1A5C3, 17'h00FFF, 8'h3C, 8'hC7, 6);
    check("R2 one load", n_ld, n0 + 1);
    check("R3 addr at WE fall", ld_addr, 17'h1A5C3);
    check("R4 data at CE rise", ld_data, 8'hC7);
  endtask

  task automatic t_ce_last_we_rise();
    int n0 = n_ld;
    do_write(0, 0, 17'h04321, 17'h1FFFF, 8'hAA, 8'h96, 8);
    check("R2 one load", n_ld, n0 + 1);
    check("R3 addr at CE fall", ld_addr, 17'h04321);
    check("R4 data at WE rise", ld_data, 8'h96);
  endtask

  task automatic t_glitch();
    int n0 = n_ld;
    do_write(1, 0, 17'h0BEEF, 17'h0BEEF, 8'h01, 8'h02, GL - 1);
    check("R5 short window dropped", n_ld, n0);
    check("R5 addr kept", ld_addr, 17'h04321);
    check("R5 data kept", ld_data, 8'h96);
    do_write(1, 0, 17'h0CAFE, 17'h0CAFE, 8'h03, 8'h04, GL);
    check("R5 minimum window accepted", n_ld, n0 + 1);
    check("R5 minimum window data", ld_data, 8'h04);
  endtask

  task automatic t_oe();
    int n0 = n_ld;
    @(negedge clk);
    addr = 17'h00777; din = 8'h77;
    ce_n = 1'b0; we_n = 1'b0;
    idle(5);
    oe_n = 1'b0;
    idle(3);
    ce_n = 1'b1; we_n = 1'b1;
    idle(2);
    oe_n = 1'b1;
    idle(6);
    check("R6 OE abort", n_ld, n0);
    @(negedge clk);
    oe_n = 1'b0;
    idle(2);
    ce_n = 1'b0; we_n = 1'b0;
    idle(6);
    ce_n = 1'b1; we_n = 1'b1;
    idle(2);
    oe_n = 1'b1;
    idle(6);
    check("R6 OE low throughout", n_ld, n0);
    check("R6 data kept", ld_data, 8'h04);
  endtask

  task automatic t_supply();
    int n0 = n_ld;
    @(negedge clk); vcc_ok = 1'b0;
    idle(4);
    do_write(1, 1, 17'h00055, 17'h00055, 8'h55, 8'h55, 6);
    check("R8 blocked while supply low", n_ld, n0);
    @(negedge clk); vcc_ok = 1'b1;
    idle(20);
    do_write(1, 1, 17'h00066, 17'h00066, 8'h66, 8'h66, 6);
    check("R7 relock after supply drop", n_ld, n0);
    check("R10 data held", ld_data, 8'h04);
    idle(POR);
    do_write(0, 1, 17'h00099, 17'h00001, 8'h00, 8'h99, 5);
    check("R7 accepted after lockout", n_ld, n0 + 1);
    check("R8 addr after recovery", ld_addr, 17'h00099);
  endtask

  task automatic t_read();
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    idle(3);
    check("R9 read enabled", rd_drive, 1);
    oe_n = 1'b1; idle(3);
    check("R9 OE high", rd_drive, 0);
    oe_n = 1'b0; we_n = 1'b0; idle(3);
    check("R9 WE low", rd_drive, 0);
    we_n = 1'b1; ce_n = 1'b1; idle(3);
    check("R9 CE high", rd_drive, 0);
    oe_n = 1'b1; idle(3);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_por_early();
    t_we_last_ce_rise();
    t_ce_last_we_rise();
    t_glitch();
    t_oe();
    t_supply();
    t_read();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule